// File: doc/BRIEF.md
# Empty-Column-First Input Arbiter

This block is the scheduler for one input port of an N-port switch whose crossbar holds a small buffer at every crosspoint. In each cell slot it looks at three things. The first is which of its own virtual output queues hold a cell. The second is which of its own crosspoint buffers have room. The third is the occupancy of every crosspoint buffer in the fabric. From these it picks at most one destination output, and the head cell of that queue then moves into the input's crosspoint buffer for that output.

The arbiter favours a destination whose whole output column is empty. A cell sent there reaches an output that has nothing else to send, so that output stays busy. When no eligible destination has an empty column, the arbiter uses plain round-robin from its priority pointer. A build option adds a one-hot remove-request. It goes to the output chosen by the round-robin fallback and asks that output to favour this input's cell. Every clock edge is one cell slot. All inputs are sampled on that edge and every output is registered.

Top module: `ecf_input_arbiter`

## Requirements
- R1: Output j can be granted only if `voq_nonempty[j]` was 1 and `own_full[j]` was 0 in the sampled slot.
- R2: If any eligible output has an empty column, the grant goes to one of those outputs. Column j is empty when bit i*NPORT+j of `xp_occupied` is 0 for every input i.
- R3: If several eligible outputs have empty columns, the grant goes to the first of them found by scanning upward from the pointer, with wrap-around.
- R4: If no eligible output has an empty column, the grant goes to the first eligible output found by scanning upward from the pointer, with wrap-around.
- R5: After a round-robin grant to output k, the pointer becomes k+1, or 0 when k is NPORT-1.
- R6: The pointer does not change after an empty-column grant or after a slot with no grant.
- R7: If no output is eligible, `grant` is all zero and `grant_valid` is 0 in the following cycle.
- R8: `grant` is one-hot or zero. It shows the decision for the inputs sampled on the previous clock edge, and `grant_valid` is 1 exactly when `grant` is non-zero.
- R9: With REMOVE_EN=1, `remove_req` equals `grant` after a round-robin grant and is zero otherwise. With REMOVE_EN=0 it is always zero.
- R10: While `rst_n` is 0, all outputs are 0. The pointer restarts at output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock; one rising edge per cell slot |
| rst_n | input | 1 | Active-low reset, synchronous |
| voq_nonempty | input | NPORT | Bit j: this input's queue toward output j holds a cell |
| own_full | input | NPORT | Bit j: this input's crosspoint buffer toward output j has no room |
| xp_occupied | input | NPORT*NPORT | Bit i*NPORT+j: crosspoint buffer (input i, output j) holds a cell |
| grant | output | NPORT | One-hot chosen output, registered |
| grant_valid | output | 1 | A grant is present this slot |
| remove_req | output | NPORT | One-hot remove-request toward the chosen output after a round-robin grant |

## Verification
Two functions can compete for the same slot. The empty-column pick and the round-robin fallback can both have a candidate at once, and the bench provokes this with column masks that leave some eligible columns empty and others busy. A slot is judged correct when the grant goes to the empty column, `remove_req` stays low and the pointer does not move. The pointer is checked through the next all-busy slot, whose round-robin grant must start from the old pointer position.

// File: rtl/ecf_pkg.sv
package ecf_pkg;

   localparam int ECF_MIN_PORTS = 2;
   localparam int ECF_MAX_PORTS = 16;

   typedef enum logic [1:0] {
      SRC_NONE        = 2'd0,
      SRC_EMPTY_COL   = 2'd1,
      SRC_ROUND_ROBIN = 2'd2
   } grant_src_e;

endpackage

// File: rtl/ecf_col_scan.sv
module ecf_col_scan #(
   parameter int NPORT = 4
) (
   input  logic [NPORT*NPORT-1:0] xp_occupied,
   output logic [NPORT-1:0]       col_empty
);

   for (genvar c = 0; c < NPORT; c++) begin : g_col
      logic [NPORT-1:0] col_bits;
      for (genvar r = 0; r < NPORT; r++) begin : g_row
         assign col_bits[r] = xp_occupied[r*NPORT + c];
      end
      assign col_empty[c] = ~|col_bits;
   end

endmodule

// File: rtl/ecf_rr_pick.sv
module ecf_rr_pick #(
   parameter int NPORT = 4,
   localparam int PW = $clog2(NPORT)
) (
   input  logic [NPORT-1:0] req,
   input  logic [PW-1:0]    start,
   output logic             hit,
   output logic [PW-1:0]    idx
);

   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int k = 0; k < NPORT; k++) begin
         int cand;
         cand = int'(start) + k;
         if (cand >= NPORT) cand = cand - NPORT;
         if (!hit && req[cand]) begin
            hit = 1'b1;
            idx = PW'(cand);
         end
      end
   end

endmodule

// File: rtl/ecf_input_arbiter.sv
module ecf_input_arbiter
   import ecf_pkg::*;
#(
   parameter int NPORT     = 4,
   parameter bit REMOVE_EN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NPORT-1:0]       voq_nonempty,
   input  logic [NPORT-1:0]       own_full,
   input  logic [NPORT*NPORT-1:0] xp_occupied,
   output logic [NPORT-1:0]       grant,
   output logic                   grant_valid,
   output logic [NPORT-1:0]       remove_req
);

   localparam int PW = $clog2(NPORT);
   localparam logic [PW-1:0] LAST = PW'(NPORT - 1);

   if (NPORT < ECF_MIN_PORTS || NPORT > ECF_MAX_PORTS) begin : g_bad_nport
      $error("ecf_input_arbiter: NPORT out of supported range");
   end

   logic [NPORT-1:0] eligible;
   logic [NPORT-1:0] col_empty;
   logic [NPORT-1:0] ecf_req;
   logic             ecf_hit, rr_hit;
   logic [PW-1:0]    ecf_idx, rr_idx;
   logic [PW-1:0]    ptr_q, ptr_d;
   logic [PW-1:0]    sel_idx;
   logic [NPORT-1:0] sel_onehot;
   logic [NPORT-1:0] rm_d;
   grant_src_e       src;

   assign eligible = voq_nonempty & ~own_full;
   assign ecf_req  = eligible & col_empty;

   ecf_col_scan #(.NPORT(NPORT)) i_col_scan (
      .xp_occupied (xp_occupied),
      .col_empty   (col_empty)
   );

   ecf_rr_pick #(.NPORT(NPORT)) i_pick_empty (
      .req   (ecf_req),
      .start (ptr_q),
      .hit   (ecf_hit),
      .idx   (ecf_idx)
   );

   ecf_rr_pick #(.NPORT(NPORT)) i_pick_rr (
      .req   (eligible),
      .start (ptr_q),
      .hit   (rr_hit),
      .idx   (rr_idx)
   );

   always_comb begin
      if (ecf_hit)     src = SRC_EMPTY_COL;
      else if (rr_hit) src = SRC_ROUND_ROBIN;
      else             src = SRC_NONE;
   end

   assign sel_idx    = ecf_hit ? ecf_idx : rr_idx;
   assign sel_onehot = (src == SRC_NONE) ? '0 : (NPORT'(1) << sel_idx);

   always_comb begin
      ptr_d = ptr_q;
      if (src == SRC_ROUND_ROBIN) begin
         ptr_d = (rr_idx == LAST) ? '0 : rr_idx + PW'(1);
      end
   end

   if (REMOVE_EN) begin : g_remove
      assign rm_d = (src == SRC_ROUND_ROBIN) ? sel_onehot : '0;
   end else begin : g_no_remove
      assign rm_d = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q       <= '0;
         grant       <= '0;
         grant_valid <= 1'b0;
         remove_req  <= '0;
      end else begin
         ptr_q       <= ptr_d;
         grant       <= sel_onehot;
         grant_valid <= (src != SRC_NONE);
         remove_req  <= rm_d;
      end
   end

   // R8: at most one output granted
   p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R8: valid strobe agrees with grant vector
   p_valid_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid == (|grant));

   // R1: grant only to an output that was eligible one slot earlier
   p_eligible_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((grant & ~$past(eligible)) == '0));

   // R2: an empty eligible column takes precedence
   p_empty_pref_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|ecf_req) |=> ((grant & $past(ecf_req)) != '0));

   // R7: nothing eligible gives no grant
   p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (eligible == '0) |=> !grant_valid);

   // R6: pointer holds unless the fallback granted
   p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (src != SRC_ROUND_ROBIN) |=> $stable(ptr_q));

   // R9: remove-request only toward the granted output
   p_remove_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (remove_req != '0) |-> (remove_req == grant));

   // R5: pointer stays inside the port range
   p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ptr_q) < NPORT);

endmodule

// File: tb/test_ecf_input_arbiter.sv
`timescale 1ns/1ps
module test_ecf_input_arbiter;

   localparam int N = 4;
   localparam real HALF = 2.5;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   voq_nonempty = '0;
   logic [N-1:0]   own_full = '0;
   logic [N*N-1:0] xp_occupied = '0;
   logic [N-1:0]   grant;
   logic           grant_valid;
   logic [N-1:0]   remove_req;

   int n_checks = 0;
   int n_fail   = 0;
   int mptr     = 0;
   logic [N-1:0] exp_g;
   logic [N-1:0] exp_rm;
   bit           exp_rr;
   bit           done = 1'b0;

   always #(HALF) clk = ~clk;

   ecf_input_arbiter #(.NPORT(N), .REMOVE_EN(1'b1)) i_ecf_input_arbiter (
      .clk          (clk),
      .rst_n        (rst_n),
      .voq_nonempty (voq_nonempty),
      .own_full     (own_full),
      .xp_occupied  (xp_occupied),
      .grant        (grant),
      .grant_valid  (grant_valid),
      .remove_req   (remove_req)
   );

   task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // reference: first eligible empty column from pointer, else first eligible
   task automatic model(input logic [N-1:0] v, input logic [N-1:0] f,
                        input logic [N*N-1:0] o, output logic [N-1:0] g, output bit rr);
      logic [N-1:0] el;
      logic [N-1:0] empt;
      int pick;
      el = v & ~f;
      for (int c = 0; c < N; c++) begin
         empt[c] = 1'b1;
         for (int r = 0; r < N; r++) if (o[r*N+c]) empt[c] = 1'b0;
      end
      pick = -1;
      rr   = 1'b0;
      for (int k = 0; k < N; k++)
         if (pick < 0 && el[(mptr+k)%N] && empt[(mptr+k)%N]) pick = (mptr+k)%N;
      if (pick < 0) begin
         for (int k = 0; k < N; k++)
            if (pick < 0 && el[(mptr+k)%N]) pick = (mptr+k)%N;
         if (pick >= 0) begin
            rr   = 1'b1;
            mptr = (pick + 1) % N;
         end
      end
      g = (pick < 0) ? '0 : (N'(1) << pick);
   endtask

   // called at a falling edge; drives, then checks at the next falling edge
   // exp_idx: >=0 directed output, -1 no grant, -2 model only
   task automatic step(input logic [N-1:0] v, input logic [N-1:0] f,
                       input logic [N*N-1:0] o, input string tag, input int exp_idx);
      voq_nonempty = v;
      own_full     = f;
      xp_occupied  = o;
      model(v, f, o, exp_g, exp_rr);
      exp_rm = exp_rr ? exp_g : '0;
      @(negedge clk);
      check(tag, grant, exp_g);
      check("R8", {{(N-1){1'b0}}, grant_valid}, {{(N-1){1'b0}}, |exp_g});
      check("R9", remove_req, exp_rm);
      if (exp_idx >= 0) check(tag, grant, N'(1) << exp_idx);
      if (exp_idx == -1) check(tag, grant, '0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      voq_nonempty = '1;
      xp_occupied  = 16'h000F;
      repeat (3) @(negedge clk);
      // R10: outputs held low during reset
      check("R10", grant, '0);
      check("R10", remove_req, '0);
      check("R10", {{(N-1){1'b0}}, grant_valid}, '0);
      rst_n = 1'b1;
      mptr  = 0;
      step('1, '0, 16'h000F, "R10", 0);    // pointer starts at 0
      step('1, '0, 16'h000F, "R5", 1);
      step('1, '0, 16'h000E, "R2", 0);     // only column 0 empty
      step('1, '0, 16'h000F, "R6", 2);     // pointer kept at 2
      step('1, '0, 16'h000F, "R5", 3);
      step(4'b0010, '0, 16'h000F, "R4", 1); // pointer wrapped to 0
      step('1, '0, 16'h0006, "R3", 3);     // columns 0 and 3 empty, ptr 2
      step('1, 4'b0100, 16'h000B, "R1", 3); // empty column 2 has no room
      step('0, '0, 16'h0000, "R7", -1);
      step('1, '1, 16'h0000, "R1", -1);
      step('1, '0, 16'h000F, "R6", 0);     // pointer 0 after idle slots
      for (int t = 0; t < 3000; t++) begin
         logic [N-1:0]   v;
         logic [N-1:0]   f;
         logic [N*N-1:0] o;
         logic [N-1:0]   g;
         bit             rr;
         int             save;
         v = N'($urandom);
         f = N'($urandom & $urandom);
         o = (N*N)'($urandom & $urandom & $urandom);
         save = mptr;
         model(v, f, o, g, rr);
         mptr = save;
         step(v, f, o, (g == '0) ? "R7" : (rr ? "R4" : "R2"), -2);
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(2.0 * HALF * 200000.0);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule